// File: doc/BRIEF.md
# Bundle Dispersal Issue Unit

This block sits between instruction decode and register read in an in-order pipeline that fetches wide instruction words. Each accepted cycle it takes a pair of decoded bundles, three instruction slots each. Every slot carries a valid bit, a unit-class code, a group-end marker and an opaque payload. The block holds the pair and sends its instructions, in program order, onto a fixed set of execution pipelines. It sends as many as the free pipelines and the current instruction group allow.

There are five pipelines. Two are pure integer, two take memory or integer work, and one takes branches. When a group asks for more of a pipeline class than is free, the leading part goes out and the rest waits for the next cycle. A new pair is taken only once the held pair has no instruction left after the current cycle's issue. Instructions of two different pairs therefore never go out together. As a result, an endless all-integer group issues four and then two instructions, three per cycle on average. The decode side sees a single ready signal, and its inverse is the stall. A downstream stall freezes issue. A flush discards everything held.

Top module: `disp_issue_unit`

## Requirements
- R1: `in_instr` holds six slots. Slot k sits at bits [20k+19:20k]: bit 19 valid, bit 18 group-end, bits 17:16 class, bits 15:0 payload. Slots 0-2 are the earlier bundle and lower slot numbers come earlier in program order. A pair is captured on a rising edge where `in_valid` and `in_ready` are high and `flush` is low.
- R2: Output lane n is pipeline n: lanes 0-1 integer, lanes 2-3 memory/integer, lane 4 branch. Class 0 is integer, class 1 is memory, class 2 is branch, and class 3 is handled as integer. An integer instruction takes the lowest free integer lane, or else the lowest free memory/integer lane. A memory instruction may take only lanes 2-3, and a branch only lane 4.
- R3: The instructions issued in a cycle are the earliest unissued ones of the held pair, taken in program order. Issue stops at the first instruction that finds no free lane of its class.
- R4: No instruction that follows a set group-end marker issues in the same cycle as the instruction that carries the marker.
- R5: Instructions held back by a split issue go out in later cycles. Each instruction issues exactly once. A valid lane reports the slot number (0-5) in `iss_pos` and the slot payload in `iss_payload`.
- R6: A captured pair starts issuing in the cycle after capture. A new pair is captured no earlier than the cycle in which the last unissued instruction of the held pair issues, so a six-slot integer group issues 4 then 2.
- R7: `in_ready` is high when nothing is held. It is also high when every held instruction issues in the current cycle and `ds_stall` is low. Otherwise it is low, and low `in_ready` is the stall toward decode.
- R8: While `ds_stall` is high, no lane is valid, the held instructions are kept unchanged, and `in_ready` is low when anything is held.
- R9: In a cycle with `flush` high, no lane is valid and the offered pair is not captured. All held instructions are discarded, so the next cycle shows no issue and high `in_ready`.
- R10: After reset no lane is valid and `in_ready` is high.
- R11: A slot with its valid bit clear never issues and takes no lane. A pair with no valid slot issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A bundle pair is offered |
| in_instr | input | 120 | Six packed instruction slots |
| in_ready | output | 1 | Pair will be taken; low means stall decode |
| ds_stall | input | 1 | Downstream stall, freezes issue |
| flush | input | 1 | Discard all held instructions |
| iss_valid | output | 5 | Per-pipeline issue valid |
| iss_pos | output | 15 | Per-pipeline slot number, 3 bits each |
| iss_payload | output | 80 | Per-pipeline payload, 16 bits each |

## Verification
The hardest situation to reach from the ports is a new pair arriving in the same cycle that the old pair's last instructions leave. This is the only cycle in which capture and issue overlap, and a fault there either mixes pairs or drops a cycle of throughput. The bench reaches it by holding `in_valid` high with successive all-integer pairs. It checks the 4/2 issue rhythm, the ready pulse in the draining cycle, and which pair each lane's payload comes from. It also drives table rows mixing class exhaustion, group ends and empty slots, so that splits fall at each kind of boundary.

// File: rtl/disp_pkg.sv
package disp_pkg;

    typedef enum logic [1:0] {
        UT_INT = 2'd0,
        UT_MEM = 2'd1,
        UT_BR  = 2'd2,
        UT_ALT = 2'd3
    } utype_e;

    typedef struct packed {
        logic   vld;
        logic   eog;
        utype_e kind;
    } slot_hdr_t;

    localparam int HDR_W = $bits(slot_hdr_t);

    function automatic logic is_branch(utype_e k);
        return k == UT_BR;
    endfunction

    function automatic logic is_mem_only(utype_e k);
        return k == UT_MEM;
    endfunction

endpackage

// File: rtl/disp_hold.sv
module disp_hold
    import disp_pkg::*;
#(
    parameter int NSLOT = 6,
    parameter int PW    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             flush,
    input  logic             advance,
    input  slot_hdr_t        hdr_in  [NSLOT],
    input  logic [PW-1:0]    pay_in  [NSLOT],
    input  logic [NSLOT-1:0] issue_mask,
    output slot_hdr_t        hdr_q   [NSLOT],
    output logic [PW-1:0]    pay_q   [NSLOT],
    output logic [NSLOT-1:0] pending
);

    logic [NSLOT-1:0] new_valid;

    always_comb begin
        for (int k = 0; k < NSLOT; k++) new_valid[k] = hdr_in[k].vld;
    end

    always_ff @(posedge clk) begin
        if (rst || flush)  pending <= '0;
        else if (load)     pending <= new_valid;
        else if (advance)  pending <= pending & ~issue_mask;
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NSLOT; k++) begin
            if (rst) begin
                hdr_q[k] <= '0;
                pay_q[k] <= '0;
            end else if (load) begin
                hdr_q[k] <= hdr_in[k];
                pay_q[k] <= pay_in[k];
            end
        end
    end

    a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (pending == '0));

    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        (!advance && !load && !flush) |=> $stable(pending));

    a_r5_no_regain: assert property (@(posedge clk) disable iff (rst)
        !load |=> ((pending & ~$past(pending)) == '0));

endmodule

// File: rtl/disp_pick.sv
module disp_pick
    import disp_pkg::*;
#(
    parameter int NSLOT = 6,
    parameter int PW    = 16,
    parameter int N_INT = 2,
    parameter int N_MEM = 2,
    parameter int N_BR  = 1,
    localparam int NLANE = N_INT + N_MEM + N_BR,
    localparam int POS_W = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] pending,
    input  slot_hdr_t        hdr      [NSLOT],
    input  logic [PW-1:0]    pay      [NSLOT],
    output logic [NSLOT-1:0] issue_mask,
    output logic [NLANE-1:0] lane_vld,
    output logic [POS_W-1:0] lane_pos [NLANE],
    output logic [PW-1:0]    lane_pay [NLANE]
);

    // In-order walk: each slot claims a lane of its class or ends the cycle.
    always_comb begin
        int   ni, nm, nb, lane;
        logic stop, fit;
        issue_mask = '0;
        lane_vld   = '0;
        for (int l = 0; l < NLANE; l++) begin
            lane_pos[l] = '0;
            lane_pay[l] = '0;
        end
        ni = 0; nm = 0; nb = 0; stop = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            fit  = 1'b0;
            lane = 0;
            if (pending[i] && hdr[i].vld && !stop) begin
                if (is_branch(hdr[i].kind)) begin
                    if (nb < N_BR) begin fit = 1'b1; lane = N_INT + N_MEM + nb; nb++; end
                end else if (is_mem_only(hdr[i].kind)) begin
                    if (nm < N_MEM) begin fit = 1'b1; lane = N_INT + nm; nm++; end
                end else if (ni < N_INT) begin
                    fit = 1'b1; lane = ni; ni++;
                end else if (nm < N_MEM) begin
                    fit = 1'b1; lane = N_INT + nm; nm++;
                end
                if (fit) begin
                    issue_mask[i]  = 1'b1;
                    lane_vld[lane] = 1'b1;
                    lane_pos[lane] = POS_W'(i);
                    lane_pay[lane] = pay[i];
                    stop           = hdr[i].eog;
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

    a_r3_progress: assert property (@(posedge clk) disable iff (rst)
        (|pending) |-> (|issue_mask));

    a_r5_subset: assert property (@(posedge clk) disable iff (rst)
        ((issue_mask & ~pending) == '0));

    a_r2_lane_count: assert property (@(posedge clk) disable iff (rst)
        $countones(issue_mask) == $countones(lane_vld));

endmodule

// File: rtl/disp_issue_unit.sv
module disp_issue_unit
    import disp_pkg::*;
#(
    parameter int PAYLOAD_W        = 16,
    parameter int BUNDLES          = 2,
    parameter int SLOTS_PER_BUNDLE = 3,
    parameter int N_INT            = 2,
    parameter int N_MEM            = 2,
    parameter int N_BR             = 1,
    localparam int NSLOT  = BUNDLES * SLOTS_PER_BUNDLE,
    localparam int SLOT_W = PAYLOAD_W + HDR_W,
    localparam int NLANE  = N_INT + N_MEM + N_BR,
    localparam int POS_W  = $clog2(NSLOT)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [NSLOT*SLOT_W-1:0]    in_instr,
    output logic                       in_ready,
    input  logic                       ds_stall,
    input  logic                       flush,
    output logic [NLANE-1:0]           iss_valid,
    output logic [NLANE*POS_W-1:0]     iss_pos,
    output logic [NLANE*PAYLOAD_W-1:0] iss_payload
);

    slot_hdr_t              hdr_in   [NSLOT];
    logic [PAYLOAD_W-1:0]   pay_in   [NSLOT];
    slot_hdr_t              hdr_q    [NSLOT];
    logic [PAYLOAD_W-1:0]   pay_q    [NSLOT];
    logic [NSLOT-1:0]       pending, issue_mask;
    logic [NLANE-1:0]       lane_vld;
    logic [POS_W-1:0]       lane_pos [NLANE];
    logic [PAYLOAD_W-1:0]   lane_pay [NLANE];
    logic                   go, busy, drain_now, load;

    for (genvar k = 0; k < NSLOT; k++) begin : g_unpack
        assign hdr_in[k] = slot_hdr_t'(in_instr[k*SLOT_W + PAYLOAD_W +: HDR_W]);
        assign pay_in[k] = in_instr[k*SLOT_W +: PAYLOAD_W];
    end

    assign go        = !ds_stall && !flush;
    assign busy      = |pending;
    assign drain_now = !ds_stall && ((pending & ~issue_mask) == '0);
    assign in_ready  = !busy || drain_now;
    assign load      = in_valid && in_ready && !flush;

    disp_hold #(.NSLOT(NSLOT), .PW(PAYLOAD_W)) u_hold (
        .clk(clk), .rst(rst), .load(load), .flush(flush), .advance(go),
        .hdr_in(hdr_in), .pay_in(pay_in), .issue_mask(issue_mask),
        .hdr_q(hdr_q), .pay_q(pay_q), .pending(pending)
    );

    disp_pick #(.NSLOT(NSLOT), .PW(PAYLOAD_W), .N_INT(N_INT), .N_MEM(N_MEM), .N_BR(N_BR)) u_pick (
        .clk(clk), .rst(rst), .pending(pending), .hdr(hdr_q), .pay(pay_q),
        .issue_mask(issue_mask), .lane_vld(lane_vld), .lane_pos(lane_pos), .lane_pay(lane_pay)
    );

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        assign iss_valid[l]                        = lane_vld[l] && go;
        assign iss_pos[l*POS_W +: POS_W]           = lane_pos[l];
        assign iss_payload[l*PAYLOAD_W +: PAYLOAD_W] = lane_pay[l];
    end

    a_r6_one_pair: assert property (@(posedge clk) disable iff (rst)
        (busy && !in_ready) |=> !$changed(pending) || ds_stall || flush
                                || ((pending & ~$past(pending)) == '0));

    a_r8_quiet_lanes: assert property (@(posedge clk) disable iff (rst)
        (ds_stall && busy) |-> !in_ready);

endmodule

// File: tb/disp_issue_unit_tb.sv
module disp_issue_unit_tb;

    localparam int NS = 6, SW = 20, NL = 5, PWD = 16, PSW = 3;

    typedef struct packed {
        logic [5:0]  v;
        logic [5:0]  e;
        logic [11:0] t;
        logic [4:0]  l0; logic [14:0] p0;
        logic [4:0]  l1; logic [14:0] p1;
        logic [4:0]  l2; logic [14:0] p2;
    } row_t;

    // lane order in p fields: {L4,L3,L2,L1,L0}; class codes in t: {s5..s0}
    localparam row_t TBL [8] = '{
        // all integer, one group: R2 R3 R5
        '{6'h3F, 6'h20, 12'h000, 5'h0F, {3'd0,3'd3,3'd2,3'd1,3'd0},
          5'h03, {3'd0,3'd0,3'd0,3'd5,3'd4}, 5'h00, 15'd0},
        // mixed classes, memory runs out: R2 R3
        '{6'h3F, 6'h20, {2'd1,2'd0,2'd0,2'd2,2'd1,2'd1}, 5'h1F, {3'd2,3'd1,3'd0,3'd4,3'd3},
          5'h04, {3'd0,3'd0,3'd5,3'd0,3'd0}, 5'h00, 15'd0},
        // three groups: R4
        '{6'h3F, 6'b100101, {2'd0,2'd1,2'd2,2'd0,2'd0,2'd0}, 5'h01, 15'd0,
          5'h03, {3'd0,3'd0,3'd0,3'd2,3'd1}, 5'h15, {3'd3,3'd0,3'd4,3'd0,3'd5}},
        // empty slots skipped: R11
        '{6'b101101, 6'h20, 12'h000, 5'h0F, {3'd0,3'd5,3'd3,3'd2,3'd0},
          5'h00, 15'd0, 5'h00, 15'd0},
        // two branches: R2 R3
        '{6'h3F, 6'h20, {2'd0,2'd0,2'd0,2'd0,2'd2,2'd2}, 5'h10, {3'd0,3'd0,3'd0,3'd0,3'd0},
          5'h1F, {3'd1,3'd5,3'd4,3'd3,3'd2}, 5'h00, 15'd0},
        // class 3 as integer: R2
        '{6'h3F, 6'h20, {2'd1,2'd1,2'd1,2'd3,2'd3,2'd3}, 5'h0F, {3'd0,3'd3,3'd2,3'd1,3'd0},
          5'h0C, {3'd0,3'd5,3'd4,3'd0,3'd0}, 5'h00, 15'd0},
        // all slots empty: R11
        '{6'h00, 6'h00, 12'h000, 5'h00, 15'd0, 5'h00, 15'd0, 5'h00, 15'd0},
        // in-order block behind memory op: R3 R5
        '{6'h3F, 6'h20, {2'd0,2'd1,2'd0,2'd0,2'd0,2'd0}, 5'h0F, {3'd0,3'd3,3'd2,3'd1,3'd0},
          5'h05, {3'd0,3'd0,3'd4,3'd0,3'd5}, 5'h00, 15'd0}
    };

    logic               clk = 1'b0, rst = 1'b1;
    logic               in_valid = 1'b0, ds_stall = 1'b0, flush = 1'b0;
    logic [NS*SW-1:0]   in_instr = '0;
    logic               in_ready;
    logic [NL-1:0]      iss_valid;
    logic [NL*PSW-1:0]  iss_pos;
    logic [NL*PWD-1:0]  iss_payload;
    int                 n_chk = 0, n_err = 0;
    bit                 done = 1'b0;

    always #4 clk = ~clk;

    disp_issue_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr), .in_ready(in_ready),
        .ds_stall(ds_stall), .flush(flush), .iss_valid(iss_valid), .iss_pos(iss_pos),
        .iss_payload(iss_payload)
    );

    function automatic logic [PWD-1:0] pay(int id, int k);
        return {8'(id), 5'd0, 3'(k)};
    endfunction

    function automatic logic [NS*SW-1:0] mk(row_t r, int id);
        logic [NS*SW-1:0] w = '0;
        for (int k = 0; k < NS; k++)
            w[k*SW +: SW] = {r.v[k], r.e[k], r.t[2*k +: 2], pay(id, k)};
        return w;
    endfunction

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // drive away from the rising edge, then settle before sampling
    task automatic cyc(input logic v, input logic [NS*SW-1:0] w, input logic ds, input logic fl);
        @(negedge clk);
        in_valid = v; in_instr = w; ds_stall = ds; flush = fl;
        #1;
    endtask

    task automatic lanes(input string what, input int id, input logic [4:0] el, input logic [14:0] ep);
        chk(iss_valid == el, {what, " valid"}, iss_valid, el);
        for (int l = 0; l < NL; l++) begin
            if (el[l]) begin
                chk(iss_pos[l*PSW +: PSW] == ep[l*PSW +: PSW], {what, " pos"},
                    iss_pos[l*PSW +: PSW], ep[l*PSW +: PSW]);
                chk(iss_payload[l*PWD +: PWD] == pay(id, int'(ep[l*PSW +: PSW])), {what, " payload"},
                    iss_payload[l*PWD +: PWD], pay(id, int'(ep[l*PSW +: PSW])));
            end
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        cyc(1'b0, '0, 1'b0, 1'b0);
        rst = 1'b0;
        #1;
        chk(iss_valid == 0, "R10 reset valid", iss_valid, 0);
        chk(in_ready == 1'b1, "R10 reset ready", in_ready, 1);

        // table walk: R1 R2 R3 R4 R5 R11
        for (int r = 0; r < 8; r++) begin
            cyc(1'b1, mk(TBL[r], r + 1), 1'b0, 1'b0);
            chk(in_ready == 1'b1, "R7 idle ready", in_ready, 1);
            cyc(1'b0, '0, 1'b0, 1'b0);
            lanes("R1 R2 R3 R4 R11 c0", r + 1, TBL[r].l0, TBL[r].p0);
            chk(in_ready == (TBL[r].l1 == 0), "R7 ready c0", in_ready, TBL[r].l1 == 0);
            cyc(1'b0, '0, 1'b0, 1'b0);
            lanes("R3 R4 R5 c1", r + 1, TBL[r].l1, TBL[r].p1);
            chk(in_ready == (TBL[r].l2 == 0), "R7 ready c1", in_ready, TBL[r].l2 == 0);
            cyc(1'b0, '0, 1'b0, 1'b0);
            lanes("R4 R5 c2", r + 1, TBL[r].l2, TBL[r].p2);
            chk(in_ready == 1'b1, "R7 ready c2", in_ready, 1);
        end

        // R6: back-to-back all-integer pairs, 4/2 rhythm, no mixing
        cyc(1'b1, mk(TBL[0], 20), 1'b0, 1'b0);
        cyc(1'b1, mk(TBL[0], 21), 1'b0, 1'b0);
        lanes("R6 pair20 first", 20, TBL[0].l0, TBL[0].p0);
        chk(in_ready == 1'b0, "R7 stall while pair held", in_ready, 0);
        cyc(1'b1, mk(TBL[0], 21), 1'b0, 1'b0);
        lanes("R6 pair20 rest", 20, TBL[0].l1, TBL[0].p1);
        chk(in_ready == 1'b1, "R6 ready in draining cycle", in_ready, 1);
        cyc(1'b0, '0, 1'b0, 1'b0);
        lanes("R6 pair21 first", 21, TBL[0].l0, TBL[0].p0);
        cyc(1'b0, '0, 1'b0, 1'b0);
        lanes("R6 pair21 rest", 21, TBL[0].l1, TBL[0].p1);
        cyc(1'b0, '0, 1'b0, 1'b0);
        chk(iss_valid == 0, "R6 drained", iss_valid, 0);

        // R8: downstream stall freezes issue, offered pair ignored
        cyc(1'b1, mk(TBL[0], 30), 1'b0, 1'b0);
        cyc(1'b1, mk(TBL[1], 31), 1'b1, 1'b0);
        chk(iss_valid == 0, "R8 no issue under stall", iss_valid, 0);
        chk(in_ready == 1'b0, "R8 stall ready", in_ready, 0);
        cyc(1'b1, mk(TBL[1], 31), 1'b1, 1'b0);
        chk(iss_valid == 0, "R8 still frozen", iss_valid, 0);
        cyc(1'b0, '0, 1'b0, 1'b0);
        lanes("R8 resume first", 30, TBL[0].l0, TBL[0].p0);
        cyc(1'b0, '0, 1'b0, 1'b0);
        lanes("R8 resume rest", 30, TBL[0].l1, TBL[0].p1);
        cyc(1'b0, '0, 1'b0, 1'b0);
        chk(iss_valid == 0, "R8 nothing duplicated", iss_valid, 0);

        // R9: flush while idle drops offered pair; flush mid-pair discards rest
        cyc(1'b1, mk(TBL[0], 40), 1'b0, 1'b1);
        chk(iss_valid == 0, "R9 idle flush no issue", iss_valid, 0);
        cyc(1'b0, '0, 1'b0, 1'b0);
        chk(iss_valid == 0, "R9 offered pair not captured", iss_valid, 0);
        chk(in_ready == 1'b1, "R9 ready after idle flush", in_ready, 1);
        cyc(1'b1, mk(TBL[0], 41), 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b0, 1'b1);
        chk(iss_valid == 0, "R9 no issue in flush cycle", iss_valid, 0);
        cyc(1'b0, '0, 1'b0, 1'b0);
        chk(iss_valid == 0, "R9 held pair discarded", iss_valid, 0);
        chk(in_ready == 1'b1, "R9 ready after flush", in_ready, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule